// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from fifteen sources and turns them into one request line and a vector for a small CPU. The sources are a general I/O line, a power monitor, a sleep timer, four analog columns and eight digital blocks. Each source raises a one-cycle request pulse. The pulse is held as a pending bit, whether or not the source is enabled. A pending bit that is also enabled in its mask register counts toward the request line, and that line is gated by a global-enable input that the CPU's flag logic drives.

The CPU reaches the block through a synchronous register bus with three registers. Address 0 is the general mask, address 1 is the digital-block mask and address 2 is the vector register. When the CPU decides to take an interrupt, it pulses `irq_ack`. The controller then picks the vector in that same cycle and returns it on the following cycle, and it clears the pending bit of the source it selected. Priority is fixed and the lowest source index wins.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both mask registers read 0, no request is pending, `irq_req` is low, and the vector register reads 0.
- R2: Address 0 holds the general mask. Its bit k (k = 0..6) enables source k: 0 is the I/O line, 1 the power monitor, 2 the sleep timer and 3..6 the analog columns. Bit 7 is not stored and reads 0. Address 1 holds the digital mask, and its bit k enables source 7+k. Any other address reads 0. A write takes effect at the clock edge. A 1 enables a source and a 0 disables it.
- R3: A pulse on `src_req[i]` sets pending bit i even when source i is masked. A masked pending bit does not drive `irq_req`, but it does once its mask bit is set.
- R4: `irq_req` is high exactly when `glb_en` is 1 and at least one pending bit has its mask bit set.
- R5: Among enabled pending sources, the lowest index has priority. Source i has vector 4 + 4·i (16 bits).
- R6: With `bus_rd` high at address 2, `bus_rdata` shows the low byte of the vector of the highest-priority enabled pending source on the next cycle. It shows 0 if there is none. The read leaves the pending bits unchanged. For every address, read data appears one cycle after the read strobe.
- R7: A write to address 2 clears every pending bit, whatever the data written.
- R8: If `irq_ack` is high in a cycle, `ack_vec_valid` is high on the next cycle and `ack_vec` carries the vector chosen in the acknowledge cycle. Only the pending bit of the chosen source is cleared.
- R9: If a mask write lands in the same cycle as `irq_ack`, the choice uses the newly written mask. If that write disables the only pending source, the delivered vector is 0000h. A vector-register write in the acknowledge cycle also yields 0000h.
- R10: A request pulse in the same cycle as a clear (acknowledge or vector write) leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 15 | One-cycle request pulses, bit i = source i |
| glb_en | input | 1 | Global interrupt enable from the CPU flags |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_ack | input | 1 | CPU commits to taking an interrupt |
| ack_vec_valid | output | 1 | Vector valid, one cycle after `irq_ack` |
| ack_vec | output | 16 | Delivered vector |

## Verification
Two collisions matter most. In the first, the CPU acknowledges in the same cycle as a mask write. In the second, a source pulses in the same cycle as its pending bit is cleared. The bench provokes the first by driving `irq_ack` and a mask write together. It checks that a lone pending source that has just been masked yields vector 0000h, and that with two pending sources the one still enabled is delivered. For the second, it pulses a source during its own acknowledge and during a vector-register write. It then expects `irq_req` to stay high and a read of the vector register to return that source's vector.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    SEL_GMASK = 2'd0,
    SEL_DMASK = 2'd1,
    SEL_VECT  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int GEN_SRC = 7,
  parameter int DIG_SRC = 8,
  parameter int DW      = 8,
  localparam int NSRC   = GEN_SRC + DIG_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   cur_vec_lo,
  output logic [DW-1:0]   rdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] mask_nxt,
  output logic            vec_wr
);
  logic [GEN_SRC-1:0] gmask_q, gmask_d;
  logic [DIG_SRC-1:0] dmask_q, dmask_d;

  always_comb begin
    gmask_d = gmask_q;
    dmask_d = dmask_q;
    if (wr && addr == SEL_GMASK) gmask_d = wdata[GEN_SRC-1:0];
    if (wr && addr == SEL_DMASK) dmask_d = wdata[DIG_SRC-1:0];
  end

  assign vec_wr   = wr && (addr == SEL_VECT);
  assign mask_q   = {dmask_q, gmask_q};
  assign mask_nxt = {dmask_d, gmask_d};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gmask_q <= '0;
      dmask_q <= '0;
      rdata   <= '0;
    end else begin
      gmask_q <= gmask_d;
      dmask_q <= dmask_d;
      if (rd) begin
        case (addr)
          SEL_GMASK: rdata <= DW'(gmask_q);
          SEL_DMASK: rdata <= DW'(dmask_q);
          SEL_VECT:  rdata <= cur_vec_lo;
          default:   rdata <= '0;
        endcase
      end
    end
  end

  a_r2_gmask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_GMASK) |=> (gmask_q == $past(wdata[GEN_SRC-1:0])));
  a_r2_dmask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_DMASK) |=> (dmask_q == $past(wdata[DIG_SRC-1:0])));
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> $stable(mask_q));
endmodule

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int NSRC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            clr_all,
  input  logic [NSRC-1:0] clr_one,
  output logic [NSRC-1:0] pend_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (req[i])     pend_q[i] <= 1'b1;
      else if (clr_all || clr_one[i]) pend_q[i] <= 1'b0;
    end
  end

  a_r3_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> ((pend_q & $past(req)) == $past(req)));
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (pend_q == $past(req)));
  a_r8_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_one));
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int NSRC     = 15,
  parameter int VW       = 16,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [NSRC-1:0] cand,
  output logic [NSRC-1:0] hit,
  output logic            any,
  output logic [VW-1:0]   vec
);
  always_comb begin
    hit = '0;
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit    = '0;
        hit[i] = 1'b1;
        vec    = VW'(VEC_BASE + VEC_STEP * i);
      end
    end
    any = |cand;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int GEN_SRC  = 7,
  parameter int DIG_SRC  = 8,
  parameter int DW       = 8,
  parameter int VW       = 16,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int NSRC    = GEN_SRC + DIG_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            glb_en,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_req,
  input  logic            irq_ack,
  output logic            ack_vec_valid,
  output logic [VW-1:0]   ack_vec
);
  logic [NSRC-1:0] mask_q, mask_nxt, pend_q;
  logic [NSRC-1:0] cur_hit, ack_hit, ack_cand;
  logic            cur_any, ack_any, vec_wr;
  logic [VW-1:0]   cur_vec, ack_sel;

  ivc_regs #(.GEN_SRC(GEN_SRC), .DIG_SRC(DIG_SRC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cur_vec_lo(cur_vec[DW-1:0]), .rdata(bus_rdata),
    .mask_q(mask_q), .mask_nxt(mask_nxt), .vec_wr(vec_wr)
  );

  ivc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(src_req), .clr_all(vec_wr),
    .clr_one(ack_hit & {NSRC{irq_ack}}), .pend_q(pend_q)
  );

  // Current view: drives the request line and register reads.
  ivc_prio #(.NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_cur (
    .cand(pend_q & mask_q), .hit(cur_hit), .any(cur_any), .vec(cur_vec)
  );

  // Acknowledge view: sees same-cycle mask writes and vector-register clears.
  assign ack_cand = pend_q & mask_nxt & {NSRC{~vec_wr}};
  ivc_prio #(.NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_ack (
    .cand(ack_cand), .hit(ack_hit), .any(ack_any), .vec(ack_sel)
  );

  assign irq_req = glb_en & cur_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vec_valid <= 1'b0;
      ack_vec       <= '0;
    end else begin
      ack_vec_valid <= irq_ack;
      if (irq_ack) ack_vec <= ack_sel;
    end
  end

  a_r8_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> ack_vec_valid);
  a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vec_valid |-> (ack_vec == '0 ||
      (ack_vec >= VW'(VEC_BASE) && ack_vec <= VW'(VEC_BASE + VEC_STEP * (NSRC - 1)))));
  a_r9_empty_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !ack_any) |=> (ack_vec == '0));
  a_r4_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq_req);
  a_r1_cur_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur_hit));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [14:0] src_req = '0;
  logic        glb_en = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_req, irq_ack = 0, ack_vec_valid;
  logic [15:0] ack_vec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .glb_en(glb_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_ack(irq_ack),
    .ack_vec_valid(ack_vec_valid), .ack_vec(ack_vec)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_rd = 1; bus_addr = a; cyc(); bus_rd = 0; v = int'(bus_rdata);
  endtask

  task automatic set_mask(input logic [14:0] m);
    wr(2'd0, {1'b0, m[6:0]}); wr(2'd1, m[14:7]);
  endtask

  task automatic pulse(input logic [14:0] m);
    src_req = m; cyc(); src_req = '0;
  endtask

  task automatic take(output int v);
    irq_ack = 1; cyc(); irq_ack = 0;
    chk("R8 valid after ack", int'(ack_vec_valid), 1);
    v = int'(ack_vec);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v;
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk("R1 irq after reset", int'(irq_req), 0);
    rd(2'd0, v); chk("R1 gmask reset", v, 0);
    rd(2'd1, v); chk("R1 dmask reset", v, 0);
    rd(2'd2, v); chk("R1 vector reset", v, 0);
    // R2 register layout
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 gmask bit7 unstored", v, 8'h7F);
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 dmask readback", v, 8'hA5);
    rd(2'd3, v); chk("R2 unused address", v, 0);
    set_mask('0);
    glb_en = 1;
    // R5/R6/R8 single-source sweep
    for (int i = 0; i < 15; i++) begin
      set_mask(15'(1) << i);
      pulse(15'(1) << i);
      chk("R4 irq single", int'(irq_req), 1);
      rd(2'd2, v); chk("R6 vector read", v, 4 + 4 * i);
      chk("R6 read keeps pending", int'(irq_req), 1);
      take(v); chk("R5 vector single", v, 4 + 4 * i);
      chk("R8 serviced cleared", int'(irq_req), 0);
    end
    // R5 priority over all pairs
    set_mask('1);
    for (int i = 0; i < 15; i++) begin
      for (int j = i + 1; j < 15; j++) begin
        pulse((15'(1) << i) | (15'(1) << j));
        take(v); chk("R5 pair first", v, 4 + 4 * i);
        take(v); chk("R8 pair second", v, 4 + 4 * j);
        chk("R8 pair drained", int'(irq_req), 0);
      end
    end
    // R3 masked source still pends
    set_mask('0);
    pulse(15'(1) << 5);
    chk("R3 masked no irq", int'(irq_req), 0);
    rd(2'd2, v); chk("R3 masked vector", v, 0);
    set_mask(15'(1) << 5);
    chk("R3 unmask raises irq", int'(irq_req), 1);
    // R4 global enable
    glb_en = 0; #1; chk("R4 global off", int'(irq_req), 0);
    glb_en = 1; #1; chk("R4 global on", int'(irq_req), 1);
    // R7 vector write clears everything
    set_mask('1);
    pulse(15'h4801);
    wr(2'd2, 8'hA5);
    chk("R7 cleared irq", int'(irq_req), 0);
    rd(2'd2, v); chk("R7 cleared vector", v, 0);
    // R9 mask cleared during ack, lone source
    set_mask(15'(1) << 2);
    pulse(15'(1) << 2);
    bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h00; irq_ack = 1;
    cyc(); bus_wr = 0; irq_ack = 0;
    chk("R9 lone masked valid", int'(ack_vec_valid), 1);
    chk("R9 lone masked vector", int'(ack_vec), 0);
    wr(2'd2, 8'h00);
    // R9 two pending, higher one masked during ack
    set_mask((15'(1) << 2) | (15'(1) << 9));
    pulse((15'(1) << 2) | (15'(1) << 9));
    bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h00; irq_ack = 1;
    cyc(); bus_wr = 0; irq_ack = 0;
    chk("R9 remaining source", int'(ack_vec), 40);
    wr(2'd2, 8'h00);
    // R9 vector write during ack
    set_mask('1);
    pulse(15'(1) << 6);
    bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h3C; irq_ack = 1;
    cyc(); bus_wr = 0; irq_ack = 0;
    chk("R9 clear during ack", int'(ack_vec), 0);
    // R10 request during own acknowledge
    pulse(15'(1) << 3);
    src_req = 15'(1) << 3; irq_ack = 1; cyc(); src_req = '0; irq_ack = 0;
    chk("R10 ack vector", int'(ack_vec), 16);
    chk("R10 survives ack", int'(irq_req), 1);
    wr(2'd2, 8'h00);
    // R10 request during vector write
    pulse(15'(1) << 1);
    src_req = 15'(1) << 4; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'hFF;
    cyc(); src_req = '0; bus_wr = 0;
    chk("R10 survives clear", int'(irq_req), 1);
    rd(2'd2, v); chk("R10 surviving vector", v, 20);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule